// File: doc/BRIEF.md
# Passive-Serial FPGA Configuration Master

This block loads a target FPGA that is configured over a serial link with no target-side clock. After a start command it pulls the target's configuration-request line low for a fixed time and then releases it. It then waits for the target to report through its status line that it is ready. Next it takes bitstream bytes from a valid/ready stream and clocks each one out, one bit per serial-clock rising edge. After the byte marked as last, it waits a settle time and reads the target's done line to decide whether the load worked.

The configuration-request output is an open-drain enable. When it is high, the pad is pulled low. When it is low, the pad floats and an external pull-up holds the line high. All delays are set in microseconds and converted to system-clock cycles from a clock-frequency parameter, rounding up, so every wait meets its minimum. A busy flag covers the whole sequence. The success and error flags keep the result until the next start.

Top module: `fpga_ps_loader`

## Requirements
- R1: After reset the block is idle: cfgPullLow, dclk, byteReady, busy, success and error are all 0.
- R2: A start while idle or finished sets busy and drives cfgPullLow high for exactly PULSE_CYC consecutive cycles. PULSE_CYC is PULSE_US microseconds rounded up to whole clock cycles. cfgPullLow is never high at any other time.
- R3: Each accepted byte produces exactly eight dclk rising edges. The dout value seen at the k-th rising edge of a byte is bit k of that byte, with k = 0 (least significant) first. dout only changes while dclk is low and stays stable while dclk is high.
- R4: Bytes are accepted only after statusIn has been seen high once the pulse has ended. While statusIn stays low, byteReady stays 0.
- R5: If statusIn stays low for STATUS_TO_CYC cycles after the pulse, the block stops with error=1 and success=0. No dclk edge is produced and no byte is accepted.
- R6: After the final byte's last dclk fall, doneIn is sampled once, DONE_CYC cycles later. A high level gives success=1/error=0 and a low level gives success=0/error=1. Until that point busy stays 1 and both result flags stay 0.
- R7: byteReady is never high while dclk is high. A new byte is taken only after all eight rising edges of the previous byte.
- R8: dclk is low whenever the block is not busy and after the final bit.
- R9: A start pulse while busy has no effect: no new configuration pulse appears and the stream continues.
- R10: success and error hold their value after the sequence ends and are both cleared by the next accepted start.
- R11: If no byte is offered, the block waits with dclk low and byteReady high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Begin a configuration sequence (ignored while busy) |
| byteData | input | 8 | Bitstream byte |
| byteValid | input | 1 | byteData holds a byte |
| byteLast | input | 1 | The offered byte is the final one |
| byteReady | output | 1 | Block will take the offered byte at the next edge |
| statusIn | input | 1 | Target status line, high = ready for data |
| doneIn | input | 1 | Target done line, high = configured |
| cfgPullLow | output | 1 | Open-drain enable for the configuration-request line (1 = pull low) |
| dclk | output | 1 | Serial configuration clock, target samples on rising edge |
| dout | output | 1 | Serial configuration data |
| busy | output | 1 | A sequence is in progress |
| success | output | 1 | Last sequence ended with done high |
| error | output | 1 | Last sequence timed out on status or ended with done low |

## Verification
The hardest case to reach from the ports is the single clock edge at which doneIn is sampled. A bench that just holds doneIn at a fixed level cannot tell a sampler that runs too early from one that runs too late. The stimulus therefore counts clock cycles from the final dclk fall. It flips doneIn exactly one cycle before the sampling edge, high-to-low in one run and low-to-high in another. Only a block that samples at the stated edge reports error in the first run and success in the second. A separate 256-byte sweep carries every byte value through the shifter and compares each captured rising-edge bit with the value computed in the bench.

// File: rtl/fpgaps_pkg.sv
package fpgaps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_STATUS,
    ST_FETCH,
    ST_SHIFT,
    ST_SETTLE,
    ST_FINISH
  } cfgState_t;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic load;
    logic run;
  } shiftCtl_t;

endpackage

// File: rtl/ps_loader_shifter.sv
module ps_loader_shifter
  import fpgaps_pkg::*;
#(
  parameter int SCLK_HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  shiftCtl_t  ctl,
  input  logic [7:0] loadData,
  output logic       byteDone,
  output logic       dclk,
  output logic       dout
);
  localparam int HW = (SCLK_HALF_CYC > 1) ? $clog2(SCLK_HALF_CYC) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(SCLK_HALF_CYC - 1);

  logic [7:0]    shiftQ;
  logic [2:0]    bitIdxQ;
  logic          phaseHighQ;
  logic [HW-1:0] halfCntQ;
  logic          halfEnd;

  assign halfEnd  = (halfCntQ == HALF_LAST);
  assign byteDone = ctl.run && phaseHighQ && halfEnd && (bitIdxQ == 3'd7);
  assign dclk     = phaseHighQ;
  assign dout     = shiftQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ     <= '0;
      bitIdxQ    <= '0;
      phaseHighQ <= 1'b0;
      halfCntQ   <= '0;
    end else if (ctl.load) begin
      shiftQ     <= loadData;
      bitIdxQ    <= '0;
      phaseHighQ <= 1'b0;
      halfCntQ   <= '0;
    end else if (ctl.run) begin
      if (halfEnd) begin
        halfCntQ <= '0;
        if (!phaseHighQ) begin
          phaseHighQ <= 1'b1;
        end else begin
          phaseHighQ <= 1'b0;
          shiftQ     <= {1'b0, shiftQ[7:1]};
          bitIdxQ    <= bitIdxQ + 3'd1;
        end
      end else begin
        halfCntQ <= halfCntQ + HW'(1);
      end
    end
  end

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (dclk && $past(dclk)) |-> $stable(dout)); // R3

  AST_LOAD_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !dclk); // R7

endmodule

// File: rtl/ps_loader_ctrl.sv
module ps_loader_ctrl
  import fpgaps_pkg::*;
#(
  parameter int PULSE_CYC     = 10,
  parameter int STATUS_TO_CYC = 40,
  parameter int DONE_CYC      = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      byteValid,
  input  logic      byteLast,
  input  logic      statusIn,
  input  logic      doneIn,
  input  logic      byteDone,
  output shiftCtl_t ctl,
  output logic      byteReady,
  output logic      cfgPullLow,
  output logic      busy,
  output logic      success,
  output logic      error
);
  localparam int MAX_A   = (PULSE_CYC > STATUS_TO_CYC) ? PULSE_CYC : STATUS_TO_CYC;
  localparam int MAX_CYC = (MAX_A > DONE_CYC) ? MAX_A : DONE_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] PULSE_END  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] STATUS_END = TW'(STATUS_TO_CYC - 1);
  localparam logic [TW-1:0] DONE_END   = TW'(DONE_CYC - 1);

  cfgState_t     stateQ, stateD;
  logic [TW-1:0] timerQ;
  logic          lastQ;
  logic          successQ, errorQ;
  logic          timed, startOk;

  assign startOk = (stateQ == ST_IDLE || stateQ == ST_FINISH) && startIn;
  assign timed   = (stateQ == ST_PULSE) || (stateQ == ST_WAIT_STATUS) ||
                   (stateQ == ST_SETTLE);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE, ST_FINISH: if (startIn) stateD = ST_PULSE;
      ST_PULSE:       if (timerQ == PULSE_END) stateD = ST_WAIT_STATUS;
      ST_WAIT_STATUS: begin
        if (statusIn)                  stateD = ST_FETCH;
        else if (timerQ == STATUS_END) stateD = ST_FINISH;
      end
      ST_FETCH:  if (byteValid) stateD = ST_SHIFT;
      ST_SHIFT:  if (byteDone)  stateD = lastQ ? ST_SETTLE : ST_FETCH;
      ST_SETTLE: if (timerQ == DONE_END) stateD = ST_FINISH;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      timerQ   <= '0;
      lastQ    <= 1'b0;
      successQ <= 1'b0;
      errorQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateD != stateQ || !timed) timerQ <= '0;
      else                            timerQ <= timerQ + TW'(1);
      if (stateQ == ST_FETCH && byteValid) lastQ <= byteLast;
      if (startOk) begin
        successQ <= 1'b0;
        errorQ   <= 1'b0;
      end else if (stateQ == ST_WAIT_STATUS && !statusIn && timerQ == STATUS_END) begin
        errorQ <= 1'b1;
      end else if (stateQ == ST_SETTLE && timerQ == DONE_END) begin
        successQ <= doneIn;
        errorQ   <= !doneIn;
      end
    end
  end

  assign cfgPullLow = (stateQ == ST_PULSE);
  assign byteReady  = (stateQ == ST_FETCH);
  assign busy       = (stateQ != ST_IDLE) && (stateQ != ST_FINISH);
  assign success    = successQ;
  assign error      = errorQ;
  assign ctl.load   = (stateQ == ST_FETCH) && byteValid;
  assign ctl.run    = (stateQ == ST_SHIFT);

  // run length of the pull-low pulse, kept for the checker below
  logic [TW-1:0] lowRunQ;
  always_ff @(posedge clk) begin
    if (!rstN)           lowRunQ <= '0;
    else if (cfgPullLow) lowRunQ <= (lowRunQ == '1) ? lowRunQ : lowRunQ + TW'(1);
    else                 lowRunQ <= '0;
  end

  AST_PULSE_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgPullLow) |-> (lowRunQ >= TW'(PULSE_CYC))); // R2

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(success && error)); // R6

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgPullLow) |=> !$rose(cfgPullLow)); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startIn) |=> ($stable(success) && $stable(error))); // R10

endmodule

// File: rtl/fpga_ps_loader.sv
module fpga_ps_loader
  import fpgaps_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int PULSE_US     = 5,
  parameter int DONE_US      = 10,
  parameter int STATUS_TO_US = 100,
  parameter int SCLK_HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [7:0] byteData,
  input  logic       byteValid,
  input  logic       byteLast,
  output logic       byteReady,
  input  logic       statusIn,
  input  logic       doneIn,
  output logic       cfgPullLow,
  output logic       dclk,
  output logic       dout,
  output logic       busy,
  output logic       success,
  output logic       error
);
  localparam int CYC_PER_US    = (CLK_HZ + 999_999) / 1_000_000;
  localparam int PULSE_CYC     = (PULSE_US * CYC_PER_US > 0) ? PULSE_US * CYC_PER_US : 1;
  localparam int DONE_CYC      = (DONE_US * CYC_PER_US > 0) ? DONE_US * CYC_PER_US : 1;
  localparam int STATUS_TO_CYC = (STATUS_TO_US * CYC_PER_US > 0) ? STATUS_TO_US * CYC_PER_US : 1;

  shiftCtl_t shiftCtl;
  logic      byteDone;

  ps_loader_ctrl #(
    .PULSE_CYC    (PULSE_CYC),
    .STATUS_TO_CYC(STATUS_TO_CYC),
    .DONE_CYC     (DONE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .byteValid (byteValid),
    .byteLast  (byteLast),
    .statusIn  (statusIn),
    .doneIn    (doneIn),
    .byteDone  (byteDone),
    .ctl       (shiftCtl),
    .byteReady (byteReady),
    .cfgPullLow(cfgPullLow),
    .busy      (busy),
    .success   (success),
    .error     (error)
  );

  ps_loader_shifter #(
    .SCLK_HALF_CYC(SCLK_HALF_CYC)
  ) u_shift (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (shiftCtl),
    .loadData(byteData),
    .byteDone(byteDone),
    .dclk    (dclk),
    .dout    (dout)
  );

  AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !dclk); // R7

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dclk); // R8

  AST_ERROR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rstN)
    (error && !busy) |-> (!dclk && !byteReady)); // R5

endmodule

// File: tb/fpga_ps_loader_tb.sv
module fpga_ps_loader_tb;
  localparam int CLK_HZ = 2_000_000;
  localparam int PULSE_CYC = 10;
  localparam int DONE_CYC = 20;
  localparam int STATUS_TO_CYC = 40;

  logic clk = 0, rstN = 0;
  logic startIn = 0, byteValid = 0, byteLast = 0, statusIn = 0, doneIn = 0;
  logic [7:0] byteData = 0;
  logic byteReady, cfgPullLow, dclk, dout, busy, success, error;

  int checks = 0, failures = 0;
  int riseCount = 0, acceptCount = 0, sessBase = 0, cycles = 0;
  logic [7:0] expBytes [0:511];
  logic prevDclk = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fpga_ps_loader #(.CLK_HZ(CLK_HZ), .PULSE_US(5), .DONE_US(10),
    .STATUS_TO_US(20), .SCLK_HALF_CYC(2)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .byteData(byteData),
    .byteValid(byteValid), .byteLast(byteLast), .byteReady(byteReady),
    .statusIn(statusIn), .doneIn(doneIn), .cfgPullLow(cfgPullLow),
    .dclk(dclk), .dout(dout), .busy(busy), .success(success), .error(error));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: bit capture at every dclk rise, ready/clock overlap, accept spacing
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (dclk && !prevDclk) begin
        int idx;
        idx = riseCount - sessBase;
        chk(dout === expBytes[idx / 8][idx % 8], "R3 bit value", dout, expBytes[idx / 8][idx % 8]);
        riseCount++;
      end
      if (byteReady && dclk) chk(0, "R7 ready while dclk high", 1, 0);
      if (byteReady && byteValid) begin
        chk(riseCount == 8 * acceptCount, "R7 rises before accept", riseCount, 8 * acceptCount);
        acceptCount++;
      end
    end
    prevDclk = dclk;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    chk(0, "watchdog", cycles, 150000);
    finishRun();
  end

  task automatic startSession(input int tag);
    @(negedge clk);
    startIn = 1;
    @(negedge clk);
    startIn = 0;
    chk(cfgPullLow && busy, "R2 pulse begins", cfgPullLow, 1);
    chk(!success && !error, "R10 start clears result", {success, error}, 0);
    begin
      int n = 1;
      while (cfgPullLow) begin
        @(negedge clk);
        if (cfgPullLow) n++;
      end
      chk(n == PULSE_CYC, "R2 pulse length", n, PULSE_CYC);
    end
  endtask

  task automatic waitFalls(input int n);
    int k = 0;
    logic p;
    p = dclk;
    while (k < n) begin
      @(negedge clk);
      if (p && !dclk) k++;
      p = dclk;
    end
  endtask

  task automatic runSession(input int nBytes, input int mode, input int statusDelay,
                            input int gap, input bit doneLate, input bit midStart);
    for (int i = 0; i < nBytes; i++)
      expBytes[i] = (mode == 0) ? 8'(i) : 8'(i * 37 + 11);
    sessBase = riseCount;
    statusIn = (statusDelay == 0);
    doneIn = !doneLate;
    startSession(0);
    if (statusDelay > 0) begin
      bit sawReady = 0;
      repeat (statusDelay) begin
        if (byteReady) sawReady = 1;
        @(negedge clk);
      end
      chk(!sawReady && busy, "R4 no accept before status", sawReady, 0);
      statusIn = 1;
    end
    for (int i = 0; i < nBytes; i++) begin
      bit acc;
      byteValid = 1;
      byteData = expBytes[i];
      byteLast = (i == nBytes - 1);
      acc = 0;
      while (!acc) begin
        acc = byteReady;
        @(negedge clk);
      end
      byteValid = 0;
      byteLast = 0;
      if (midStart && i == 1) begin
        startIn = 1;
        @(negedge clk);
        startIn = 0;
        @(negedge clk);
        chk(!cfgPullLow && busy, "R9 start ignored while busy", cfgPullLow, 0);
      end
      if (gap > 0 && i != nBytes - 1) begin
        repeat (gap) @(negedge clk);
        chk(!dclk && byteReady, "R11 stall clock low ready high", {dclk, byteReady}, 1);
      end
    end
    waitFalls(8);
    chk(!dclk, "R8 clock low after final bit", dclk, 0);
    repeat (DONE_CYC - 1) @(negedge clk);
    chk(busy && !success && !error, "R6 no result before sample", {busy, success, error}, 4);
    doneIn = doneLate;
    @(negedge clk);
    chk(success == doneLate && error == !doneLate && !busy, "R6 done sample result",
        {success, error}, doneLate ? 2 : 1);
    doneIn = 0;
    chk(riseCount - sessBase == 8 * nBytes, "R3 rise count", riseCount - sessBase, 8 * nBytes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cfgPullLow && !dclk && !byteReady && !busy && !success && !error, "R1 reset state",
        {cfgPullLow, dclk, byteReady, busy, success, error}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !dclk && !cfgPullLow, "R1 idle after reset", busy, 0);

    // full byte sweep, done rises just before sample -> success
    runSession(256, 0, 0, 0, 1, 0);
    repeat (10) @(negedge clk);
    chk(success && !error && !dclk, "R10 result held / R8 idle clock", {success, error}, 2);

    // delayed status, stalls, start while busy, done falls just before sample -> error
    runSession(5, 1, 7, 40, 0, 1);
    repeat (5) @(negedge clk);
    chk(error && !success, "R10 error held", {success, error}, 1);

    // single byte
    runSession(1, 1, 0, 0, 1, 0);

    // status timeout
    begin
      int r0;
      r0 = riseCount;
      statusIn = 0;
      startSession(1);
      repeat (STATUS_TO_CYC - 1) @(negedge clk);
      chk(busy && !error && !byteReady, "R5 still waiting", error, 0);
      @(negedge clk);
      chk(error && !success && !busy, "R5 timeout error", {success, error}, 1);
      repeat (10) @(negedge clk);
      chk(riseCount == r0 && !dclk && !cfgPullLow, "R5 no data shifted", riseCount - r0, 0);
    end

    // recovery after error
    runSession(3, 0, 0, 0, 1, 0);
    finishRun();
  end
endmodule